// File: doc/BRIEF.md
# Strobed Byte Input Port

This block takes bytes from an external producer into a host bus through a two-wire handshake. The producer places a byte on `dev_data` while `dev_full` is low and then raises `dev_ready`. The port watches for the rising edge of that strobe. It latches the byte and raises `dev_full` to hold off the producer until the host has read the byte. Only the rising edge counts, and the capture and back-pressure are done in logic. A strobe pulse one clock wide is therefore enough to deliver a byte.

The host reaches two registers through a registered read port. The data register returns the latched byte, and reading it releases `dev_full`. The status register shows the handshake lines and a sticky overrun flag. The host can poll the status register to see whether a byte is waiting. The line levels alone cannot tell "byte just strobed" apart from "byte already taken", so the port keeps its own captured-and-unread flag. `dev_full` follows that flag.

Top module: `strobe_in_port`

## Requirements
- R1: While `rst` is high and after it falls, `dev_full` is low, `host_rdata` is zero, and a status read returns zero.
- R2: `dev_ready` passes through a two-flop synchroniser. Only its rising edge triggers a capture. A pulse one clock wide captures a byte, and a strobe held high for many cycles captures exactly once.
- R3: `dev_full` rises at the third rising clock edge after the raw `dev_ready` edge. It is still low after the second edge.
- R4: The latched byte is the value on `dev_data` at that third clock edge.
- R5: A read with `host_addr` = 0 (data register) puts the latched byte on `host_rdata` at the clock edge that samples `host_rd`. It clears `dev_full` at that same edge.
- R6: A read with `host_addr` = 1 (status register) returns bit 0 = byte waiting (same as `dev_full`), bit 1 = synchronised `dev_ready` level, bit 2 = overrun, and zero in all other bits.
- R7: A strobe edge that arrives while `dev_full` is high leaves the latched byte unchanged and sets the overrun bit.
- R8: The overrun bit stays set until a status read. That read returns it as 1 and clears it.
- R9: A data read while no byte is waiting returns the last latched byte and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_data | input | DATA_W | Byte from the external producer |
| dev_ready | input | 1 | Asynchronous data-ready strobe from the producer |
| dev_full | output | 1 | Buffer-full back-pressure to the producer |
| host_rd | input | 1 | Host read request, one cycle per read |
| host_addr | input | ADDR_W | Register select: 0 data, 1 status |
| host_rdata | output | DATA_W | Registered read data |

## Verification
The bench times the strobe-to-full latency edge by edge. A design with a missing or extra synchroniser stage would raise `dev_full` one cycle early or late. It holds the strobe high for many cycles and then reads the data register. A level-triggered design would capture again and raise `dev_full` a second time. It strobes a second byte into a full buffer. A design that overwrote the latch would return the second byte, and one without a sticky flag would lose the overrun report. It also checks that the status read itself clears the overrun flag.

// File: rtl/sbf_pkg.sv
`timescale 1ns/1ps
package sbf_pkg;
  // register map of the host read port
  localparam int unsigned REG_DATA = 0;
  localparam int unsigned REG_STAT = 1;
  // status register bit positions
  localparam int unsigned ST_FULL  = 0;
  localparam int unsigned ST_LEVEL = 1;
  localparam int unsigned ST_OVR   = 2;
  localparam int unsigned ST_USED  = 3;
endpackage

// File: rtl/sbf_sync_edge.sv
`timescale 1ns/1ps
module sbf_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= async_in;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b0;
        else     sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  assign level = sync_q[LAST];
  assign rise  = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/sbf_capture.sv
`timescale 1ns/1ps
module sbf_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic [DATA_W-1:0] din,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] byte_q,
  output logic              full_q,
  output logic              ovr_q
);
  logic take;
  assign take = rise & ~full_q;

  always_ff @(posedge clk) begin
    if (rst)       byte_q <= '0;
    else if (take) byte_q <= din;
  end

  // captured-and-unread flag, also drives the buffer-full line
  always_ff @(posedge clk) begin
    if (rst)          full_q <= 1'b0;
    else if (take)    full_q <= 1'b1;
    else if (data_rd) full_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                 ovr_q <= 1'b0;
    else if (rise && full_q) ovr_q <= 1'b1;
    else if (stat_rd)        ovr_q <= 1'b0;
  end
endmodule

// File: rtl/sbf_bus_if.sv
`timescale 1ns/1ps
module sbf_bus_if
  import sbf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] byte_q,
  input  logic              full,
  input  logic              level,
  input  logic              ovr,
  output logic              data_rd,
  output logic              stat_rd,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rd_mux;

  assign data_rd = rd && (addr == ADDR_W'(REG_DATA));
  assign stat_rd = rd && (addr == ADDR_W'(REG_STAT));

  always_comb begin
    stat_word           = '0;
    stat_word[ST_FULL]  = full;
    stat_word[ST_LEVEL] = level;
    stat_word[ST_OVR]   = ovr;
  end

  always_comb begin
    if (data_rd)      rd_mux = byte_q;
    else if (stat_rd) rd_mux = stat_word;
    else              rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/strobe_in_port.sv
`timescale 1ns/1ps
module strobe_in_port #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dev_data,
  input  logic              dev_ready,
  output logic              dev_full,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [DATA_W-1:0] host_rdata
);
  logic              level_w;
  logic              rise_w;
  logic              data_rd_w;
  logic              stat_rd_w;
  logic              ovr_w;
  logic              full_w;
  logic [DATA_W-1:0] byte_w;

  sbf_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(dev_ready),
    .level(level_w), .rise(rise_w)
  );

  sbf_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .rise(rise_w), .din(dev_data),
    .data_rd(data_rd_w), .stat_rd(stat_rd_w),
    .byte_q(byte_w), .full_q(full_w), .ovr_q(ovr_w)
  );

  sbf_bus_if #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .rd(host_rd), .addr(host_addr),
    .byte_q(byte_w), .full(full_w), .level(level_w), .ovr(ovr_w),
    .data_rd(data_rd_w), .stat_rd(stat_rd_w), .rdata(host_rdata)
  );

  assign dev_full = full_w;
endmodule

// File: rtl/sbf_checker.sv
`timescale 1ns/1ps
module sbf_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rise,
  input logic              full,
  input logic              data_rd,
  input logic              stat_rd,
  input logic              ovr,
  input logic [DATA_W-1:0] byte_q
);
  AST_FULL_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
    (rise && !full) |=> full); // R3

  AST_FULL_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!full && !rise) |=> !full); // R2

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    full |=> $stable(byte_q)); // R7

  AST_OVR_ON_FULL_EDGE: assert property (@(posedge clk) disable iff (rst)
    (rise && full) |=> ovr); // R7

  AST_FULL_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (data_rd && full) |=> !full); // R5

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr && !stat_rd) |=> ovr); // R8

  AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(rise && full)) |=> !ovr); // R8
endmodule

bind strobe_in_port sbf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rise(rise_w), .full(full_w),
  .data_rd(data_rd_w), .stat_rd(stat_rd_w), .ovr(ovr_w), .byte_q(byte_w)
);

// File: tb/test_strobe_in_port.sv
`timescale 1ns/1ps
module test_strobe_in_port;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] dev_data = '0;
  logic          dev_ready = 1'b0;
  logic          dev_full;
  logic          host_rd = 1'b0;
  logic [0:0]    host_addr = 1'b0;
  logic [DW-1:0] host_rdata;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  strobe_in_port i_strobe_in_port (
    .clk(clk), .rst(rst), .dev_data(dev_data), .dev_ready(dev_ready),
    .dev_full(dev_full), .host_rd(host_rd), .host_addr(host_addr),
    .host_rdata(host_rdata)
  );

  // {byte, expected status after capture}: full=bit0
  localparam logic [15:0] VEC [8] = '{
    16'h00_01, 16'hFF_01, 16'hA5_01, 16'h5A_01,
    16'h01_01, 16'h80_01, 16'h7E_01, 16'hC3_01
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_read(input logic [0:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    host_rd = 1'b1;
    host_addr = a;
    @(posedge clk);
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  // one-cycle strobe, then wait until third edge has passed
  task automatic strobe(input logic [DW-1:0] d);
    @(negedge clk);
    dev_data = d;
    dev_ready = 1'b1;
    @(negedge clk);
    dev_ready = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 full in reset", 32'(dev_full), 0);
    check("R1 rdata in reset", 32'(host_rdata), 0);
    rst = 1'b0;
    host_read(1'b1, v);
    check("R1 status after reset", 32'(v), 0);

    // table walk: R2 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      strobe(VEC[i][15:8]);
      check("R2 pulse captured", 32'(dev_full), 1);
      host_read(1'b1, v);
      check("R6 status waiting", 32'(v), 32'(VEC[i][7:0]));
      host_read(1'b0, v);
      check("R4 byte value", 32'(v), 32'(VEC[i][15:8]));
      check("R5 full cleared", 32'(dev_full), 0);
    end

    // R3 latency, edge by edge
    @(negedge clk);
    dev_data = 8'h96;
    dev_ready = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R3 not before third edge", 32'(dev_full), 0);
    dev_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R3 full at third edge", 32'(dev_full), 1);
    host_read(1'b0, v);
    check("R4 latency byte", 32'(v), 32'h96);

    // R7 R8 overrun
    strobe(8'h11);
    strobe(8'h22);
    repeat (2) @(negedge clk);
    host_read(1'b1, v);
    check("R7 R8 status shows overrun", 32'(v), 32'h05);
    host_read(1'b0, v);
    check("R7 byte kept", 32'(v), 32'h11);
    host_read(1'b1, v);
    check("R8 overrun cleared by status read", 32'(v), 32'h00);

    // R2 held level captures once
    @(negedge clk);
    dev_data = 8'h3C;
    dev_ready = 1'b1;
    repeat (6) @(negedge clk);
    host_read(1'b1, v);
    check("R6 level bit while held", 32'(v), 32'h03);
    host_read(1'b0, v);
    check("R2 held byte", 32'(v), 32'h3C);
    dev_data = 8'h44;
    repeat (6) @(negedge clk);
    check("R2 no recapture on level", 32'(dev_full), 0);
    host_read(1'b1, v);
    check("R2 status still high no overrun", 32'(v), 32'h02);
    dev_ready = 1'b0;
    repeat (4) @(negedge clk);

    // R9 empty read
    host_read(1'b0, v);
    check("R9 empty read returns last", 32'(v), 32'h3C);
    host_read(1'b1, v);
    check("R9 status unchanged", 32'(v), 32'h00);

    // R1 reset mid-transfer
    strobe(8'h77);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 full cleared by reset", 32'(dev_full), 0);
    rst = 1'b0;
    host_read(1'b0, v);
    check("R1 latch cleared by reset", 32'(v), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule